// File: doc/BRIEF.md
# 1-Wire Search Responder

This block is the slave-side engine that lets a device take part in the bus identity enumeration once the command layer has decoded a search command. It sits beside the bit-slot layer: the slot layer tells it when a read slot or a write slot occurs, hands over the sampled bit of each write slot, and takes from it the bit to place on the line during each read slot. A value of 1 on the drive output means the line is released. A value of 0 means it is pulled low, so several responders answering together produce a wired-AND.

The 64-bit identity is walked from bit 0 up to bit 63. For every position the responder answers two read slots and then one write slot. It gives the identity bit, then its complement, and then takes the master's chosen value. When the chosen value differs from its own bit, the responder drops out and stays silent until the next bus reset. When it survives the last position it becomes selected. Its switch then toggles, and any further read slot reports the sensed pin level. A second search flavour admits only responders whose switch is already on.

Top module: `owsr_search_responder`

## Requirements
- R1: After rst_n is released the responder is idle: drive_bit is 1, in_search and selected are 0, sw_on is 0 and bit_idx is 0.
- R2: In idle, cmd_valid with cmd_code F0h starts the search at bit position 0. Any other code except ECh leaves the responder idle.
- R3: In the first read phase of a position, drive_bit equals rom_id[bit_idx]. A read slot moves the responder to the complement phase.
- R4: In the complement phase, drive_bit equals the inverse of rom_id[bit_idx]. A read slot moves the responder to the choice phase.
- R5: In the choice phase, a write slot whose bit equals rom_id[bit_idx] advances bit_idx by one (least significant bit first) and returns the responder to the first read phase.
- R6: In the choice phase, a write slot whose bit differs from rom_id[bit_idx] ends participation: in_search goes to 0 and drive_bit stays 1 until a bus reset.
- R7: A matching write slot at bit position 63 makes selected 1 and inverts sw_on exactly once, in the same clock.
- R8: While selected, drive_bit follows pio_sense.
- R9: In idle, cmd_code ECh starts the search only if sw_on is 1. Otherwise the responder waits for a bus reset with drive_bit at 1.
- R10: bus_reset in any state returns the responder to idle with bit_idx 0 and leaves sw_on unchanged.
- R11: A write slot during either read phase, and a read slot during the choice phase, change neither the phase, bit_idx nor sw_on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rom_id | input | 64 | Device identity, bit 0 sent first |
| bus_reset | input | 1 | Pulse: bus reset/presence detected |
| cmd_valid | input | 1 | Pulse: a command byte has been decoded |
| cmd_code | input | 8 | The decoded command byte |
| read_slot | input | 1 | Pulse: a read slot is being served |
| write_slot | input | 1 | Pulse: a write slot bit was sampled |
| write_bit | input | 1 | The sampled write slot bit |
| pio_sense | input | 1 | Sensed switch pin level |
| drive_bit | output | 1 | Bit to drive in read slots (1 = release) |
| in_search | output | 1 | Responder is inside the three-slot exchange |
| selected | output | 1 | Responder survived all positions |
| sw_on | output | 1 | Switch state (1 = pulldown on) |
| bit_idx | output | 6 | Identity position being handled |

## Verification
Each phase change, index step and switch toggle takes effect at the clock edge that samples the slot or command pulse. drive_bit is combinational on the registered phase and on pio_sense, so it is valid one cycle after the pulse that set the phase. The bench drives every input on the falling edge and advances its behavioural model at the rising edge. It compares all outputs 1 ns after that edge, so each result is checked in the cycle in which it is due.

// File: rtl/owsr_pkg.sv
`timescale 1ns/1ps
package owsr_pkg;
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_TRUE   = 3'd1,
        PH_COMP   = 3'd2,
        PH_CHOICE = 3'd3,
        PH_SEL    = 3'd4,
        PH_WAIT   = 3'd5
    } phase_e;
endpackage

// File: rtl/owsr_idbit_pick.sv
`timescale 1ns/1ps
module owsr_idbit_pick #(
    parameter int ID_W = 64,
    parameter int IW   = 6
) (
    input  logic [ID_W-1:0] id_vec,
    input  logic [IW-1:0]   sel,
    output logic            bit_o
);
    logic [ID_W-1:0] hit;

    for (genvar g = 0; g < ID_W; g++) begin : g_pick
        assign hit[g] = id_vec[g] && (sel == IW'(g));
    end

    assign bit_o = |hit;
endmodule

// File: rtl/owsr_switch_reg.sv
`timescale 1ns/1ps
module owsr_switch_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic flip,
    output logic on_o
);
    logic on_d, on_q;

    always_comb begin
        on_d = on_q;
        if (flip) on_d = ~on_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= on_d;
    end

    assign on_o = on_q;
endmodule

// File: rtl/owsr_search_responder.sv
`timescale 1ns/1ps
module owsr_search_responder
    import owsr_pkg::*;
#(
    parameter int          ID_W       = 64,
    parameter logic [7:0]  CODE_ALL   = 8'hF0,
    parameter logic [7:0]  CODE_ARMED = 8'hEC
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ID_W-1:0]          rom_id,
    input  logic                     bus_reset,
    input  logic                     cmd_valid,
    input  logic [7:0]               cmd_code,
    input  logic                     read_slot,
    input  logic                     write_slot,
    input  logic                     write_bit,
    input  logic                     pio_sense,
    output logic                     drive_bit,
    output logic                     in_search,
    output logic                     selected,
    output logic                     sw_on,
    output logic [$clog2(ID_W)-1:0]  bit_idx
);
    localparam int IW = $clog2(ID_W);
    localparam logic [IW-1:0] LAST = IW'(ID_W - 1);

    typedef struct packed {
        phase_e        ph;
        logic [IW-1:0] idx;
    } core_t;

    core_t cur_q, cur_d;
    logic  flip_d;
    logic  own_bit;

    owsr_idbit_pick #(.ID_W(ID_W), .IW(IW)) u_pick (
        .id_vec (rom_id),
        .sel    (cur_q.idx),
        .bit_o  (own_bit)
    );

    owsr_switch_reg u_sw (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (flip_d),
        .on_o  (sw_on)
    );

    always_comb begin
        cur_d  = cur_q;
        flip_d = 1'b0;
        if (bus_reset) begin
            cur_d.ph  = PH_IDLE;
            cur_d.idx = '0;
        end else begin
            unique case (cur_q.ph)
                PH_IDLE: begin
                    if (cmd_valid) begin
                        if (cmd_code == CODE_ALL)
                            cur_d.ph = PH_TRUE;
                        else if (cmd_code == CODE_ARMED)
                            cur_d.ph = sw_on ? PH_TRUE : PH_WAIT;
                    end
                end
                PH_TRUE:   if (read_slot) cur_d.ph = PH_COMP;
                PH_COMP:   if (read_slot) cur_d.ph = PH_CHOICE;
                PH_CHOICE: begin
                    if (write_slot) begin
                        if (write_bit != own_bit) begin
                            cur_d.ph = PH_WAIT;
                        end else if (cur_q.idx == LAST) begin
                            cur_d.ph = PH_SEL;
                            flip_d   = 1'b1;
                        end else begin
                            cur_d.idx = cur_q.idx + 1'b1;
                            cur_d.ph  = PH_TRUE;
                        end
                    end
                end
                default: cur_d = cur_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.ph  <= PH_IDLE;
            cur_q.idx <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    always_comb begin
        unique case (cur_q.ph)
            PH_TRUE: drive_bit = own_bit;
            PH_COMP: drive_bit = ~own_bit;
            PH_SEL:  drive_bit = pio_sense;
            default: drive_bit = 1'b1;
        endcase
    end

    assign in_search = (cur_q.ph == PH_TRUE) || (cur_q.ph == PH_COMP) ||
                       (cur_q.ph == PH_CHOICE);
    assign selected  = (cur_q.ph == PH_SEL);
    assign bit_idx   = cur_q.idx;

    a_r10_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> (bit_idx == '0) && !in_search && !selected);

    a_r5_index_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bit_idx) |-> (bit_idx == '0) || (bit_idx == $past(bit_idx) + 1'b1));

    a_r7_flip_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> (sw_on != $past(sw_on)));

    a_r11_switch_only_on_select: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_on) |-> $rose(selected));

    a_r6_silent_after_dropout: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(in_search) && !selected && !$past(bus_reset)) |-> drive_bit);
endmodule

// File: tb/tb_owsr_search_responder.sv
`timescale 1ns/1ps
module tb_owsr_search_responder;
    localparam logic [63:0] ID = 64'hA5C3_0F1E_7B29_6D05;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_reset = 0, cmd_valid = 0, read_slot = 0, write_slot = 0;
    logic write_bit = 0, pio_sense = 0;
    logic [7:0] cmd_code = 8'h00;
    logic drive_bit, in_search, selected, sw_on;
    logic [5:0] bit_idx;

    int checks = 0;
    int fails = 0;
    string tag = "R1";

    int   m_st = 0;
    int   m_idx = 0;
    logic m_sw = 1'b0;

    always #2.5 clk = ~clk;

    owsr_search_responder dut (
        .clk(clk), .rst_n(rst_n), .rom_id(ID), .bus_reset(bus_reset),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code), .read_slot(read_slot),
        .write_slot(write_slot), .write_bit(write_bit), .pio_sense(pio_sense),
        .drive_bit(drive_bit), .in_search(in_search), .selected(selected),
        .sw_on(sw_on), .bit_idx(bit_idx)
    );

    task automatic model_edge();
        if (!rst_n) begin
            m_st = 0; m_idx = 0; m_sw = 1'b0;
        end else if (bus_reset) begin
            m_st = 0; m_idx = 0;
        end else begin
            case (m_st)
                0: if (cmd_valid) begin
                       if (cmd_code == 8'hF0) m_st = 1;
                       else if (cmd_code == 8'hEC) m_st = m_sw ? 1 : 5;
                   end
                1: if (read_slot) m_st = 2;
                2: if (read_slot) m_st = 3;
                3: if (write_slot) begin
                       if (write_bit !== ID[m_idx]) m_st = 5;
                       else if (m_idx == 63) begin m_st = 4; m_sw = ~m_sw; end
                       else begin m_idx++; m_st = 1; end
                   end
                default: ;
            endcase
        end
    endtask

    task automatic compare();
        logic e_drv;
        e_drv = (m_st == 1) ? ID[m_idx] : (m_st == 2) ? ~ID[m_idx] :
                (m_st == 4) ? pio_sense : 1'b1;
        checks++;
        if (drive_bit !== e_drv || in_search !== (m_st >= 1 && m_st <= 3) ||
            selected !== (m_st == 4) || sw_on !== m_sw || bit_idx !== 6'(m_idx)) begin
            fails++;
            $display("FAIL %s: drv=%b srch=%b sel=%b sw=%b idx=%0d expected drv=%b srch=%b sel=%b sw=%b idx=%0d",
                     tag, drive_bit, in_search, selected, sw_on, bit_idx,
                     e_drv, (m_st >= 1 && m_st <= 3), (m_st == 4), m_sw, m_idx);
        end
    endtask

    task automatic step(input logic rd, input logic wr, input logic wb,
                        input logic br, input logic cv, input logic [7:0] cc,
                        input logic ps);
        @(negedge clk);
        read_slot = rd; write_slot = wr; write_bit = wb; bus_reset = br;
        cmd_valid = cv; cmd_code = cc; pio_sense = ps;
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 8'h00, pio_sense);
    endtask

    task automatic position(input logic choice);
        step(1, 0, 0, 0, 0, 8'h00, 0); idle(1);
        step(1, 0, 0, 0, 0, 8'h00, 0); idle(1);
        step(0, 1, choice, 0, 0, 8'h00, 0); idle(1);
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        tag = "R1";
        idle(3);
        @(negedge clk); rst_n = 1'b1;
        idle(3);

        tag = "R2";
        step(0, 0, 0, 0, 1, 8'h33, 0); idle(2);
        step(0, 0, 0, 0, 1, 8'hF0, 0); idle(1);

        tag = "R11";
        step(0, 1, ~ID[0], 0, 0, 8'h00, 0); idle(1);
        tag = "R3";
        step(1, 0, 0, 0, 0, 8'h00, 0); idle(1);
        tag = "R11";
        step(0, 1, ~ID[0], 0, 0, 8'h00, 0);
        tag = "R4";
        step(1, 0, 0, 0, 0, 8'h00, 0); idle(1);
        tag = "R11";
        step(1, 0, 0, 0, 0, 8'h00, 0);
        tag = "R5";
        step(0, 1, ID[0], 0, 0, 8'h00, 0); idle(1);
        for (int i = 1; i < 63; i++) position(ID[i]);
        tag = "R7";
        position(ID[63]);
        tag = "R8";
        step(1, 0, 0, 0, 0, 8'h00, 1);
        step(1, 0, 0, 0, 0, 8'h00, 0);
        step(0, 0, 0, 0, 0, 8'h00, 1);

        tag = "R10";
        step(0, 0, 0, 1, 0, 8'h00, 0); idle(1);
        tag = "R9";
        step(0, 0, 0, 0, 1, 8'hEC, 0); idle(1);
        for (int i = 0; i < 5; i++) position(ID[i]);
        tag = "R6";
        position(~ID[5]);
        step(1, 0, 0, 0, 0, 8'h00, 0);
        step(0, 1, ID[5], 0, 0, 8'h00, 0);
        idle(2);

        tag = "R10";
        step(0, 0, 0, 1, 0, 8'h00, 0);
        step(0, 0, 0, 0, 1, 8'hF0, 0);
        for (int i = 0; i < 10; i++) position(ID[i]);
        step(1, 0, 0, 0, 0, 8'h00, 0);
        step(0, 0, 0, 1, 0, 8'h00, 0); idle(2);

        tag = "R7";
        step(0, 0, 0, 0, 1, 8'hF0, 0);
        for (int i = 0; i < 64; i++) position(ID[i]);
        step(0, 0, 0, 1, 0, 8'h00, 0);

        tag = "R9";
        step(0, 0, 0, 0, 1, 8'hEC, 0);
        step(1, 0, 0, 0, 0, 8'h00, 0);
        step(0, 1, ID[0], 0, 0, 8'h00, 0);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule